// File: doc/BRIEF.md
# I2C Command Target with Response Queue

This block is the serial front end through which an external supervisory microcontroller talks to command logic inside the FPGA. The microcontroller is always the bus controller. The block only ever answers as a target. SCL and SDA are oversampled on the system clock. The block finds START and STOP conditions and tracks each transfer byte by byte. When the address byte names this target, the block acknowledges it. In a write transfer, the first byte after the address is a command byte and every byte after that is a data byte. Each of these bytes is handed to a command decoder through a one-cycle byte strobe, and a flag tells the decoder whether the byte is the command.

A read transfer returns bytes that earlier commands left in a small response queue. The command logic fills this queue through a push strobe. The target shifts the queued bytes out in the order they were pushed, and it keeps sending until the controller answers a byte with NACK. Only one target address answers. The address compare sits in one place so that more targets could be added later.

Top module: `i2c_cmd_target`

## Requirements
- R1: After reset the target does not pull SDA low and raises no byte strobe.
- R2: A first byte whose upper seven bits equal `DEV_ADDR` is acknowledged: SDA is held low through the ninth SCL pulse. Bit 0 of that byte selects the direction, 1 = read and 0 = write.
- R3: A first byte with any other address gets no acknowledge. The rest of that transfer is not acknowledged and raises no byte strobe.
- R4: In a write transfer to this target, the byte after the address raises `rxStrobe` with `rxIsCmd` = 1. Every byte after it raises `rxStrobe` with `rxIsCmd` = 0. `rxData` carries the byte, MSB first on the bus.
- R5: Every command byte and data byte of a write transfer to this target is acknowledged.
- R6: In a read transfer, the target sends the queued response bytes MSB first, in the order they were pushed.
- R7: When the response queue is empty, a read returns 0xFF.
- R8: A NACK from the controller after a read byte ends the transmission. The target releases SDA and takes no further byte from the queue.
- R9: The response queue holds `FIFO_DEPTH` (16) bytes. A push while the queue is full is dropped.
- R10: A STOP returns the target to idle, even in the middle of a byte. A repeated START restarts decoding at the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line as seen at the pad |
| sdaIn | input | 1 | SDA line as seen at the pad |
| sdaDriveLow | output | 1 | When 1, the pad pulls SDA low (open-drain) |
| rxStrobe | output | 1 | One-cycle pulse: a received write byte is valid |
| rxIsCmd | output | 1 | Qualifies rxStrobe: the byte is the command byte |
| rxData | output | 8 | Received byte |
| rspPush | input | 1 | Push strobe into the response queue |
| rspData | input | 8 | Byte to push |

## Verification
The assertions check on every cycle that:
- SDA is pulled low only in an acknowledge slot or while sending read data;
- byte strobes appear only in write transfers;
- a STOP always leads to idle;
- the response queue never counts past its depth, keeps its count when a push arrives while full, and loads 0xFF when it is read while empty.

Only the bench scenarios can show the behaviour seen across whole transfers:
- the order of bytes coming out of the queue;
- the correct command and data flags over several bytes;
- silence toward a foreign address;
- a clean restart after an aborted or restarted transfer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } tgtState_t;

  // bus events seen by the control, produced by the datapath
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic sdaBit;
    logic addrMatch;
    logic rwBit;
  } busEvt_t;

  // strobes and levels from the control into the datapath
  typedef struct packed {
    logic shiftIn;
    logic emitByte;
    logic emitIsCmd;
    logic loadTx;
    logic shiftTx;
    logic ackLow;
    logic txEn;
  } ctrlStb_t;

endpackage

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int FIFO_DEPTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  ctrlStb_t   stb,
  output busEvt_t    evt,
  output logic       sdaDriveLow,
  output logic       rxStrobe,
  output logic       rxIsCmd,
  output logic [7:0] rxData,
  input  logic       rspPush,
  input  logic [7:0] rspData
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FIFO_DEPTH - 1);

  // ---------------- input synchronizers ----------------
  logic sclS, sdaS, sclD, sdaD;

  generate
    if (SYNC_STAGES > 1) begin : g_sync
      logic [SYNC_STAGES-1:0] sclSync, sdaSync;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
      assign sclS = sclSync[SYNC_STAGES-1];
      assign sdaS = sdaSync[SYNC_STAGES-1];
    end else begin : g_sync1
      logic sclQ, sdaQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclQ <= 1'b1;
          sdaQ <= 1'b1;
        end else begin
          sclQ <= sclIn;
          sdaQ <= sdaIn;
        end
      end
      assign sclS = sclQ;
      assign sdaS = sdaQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  // ---------------- receive shifter ----------------
  logic [7:0] rxShift;
  logic [7:0] rxNext;
  assign rxNext = {rxShift[6:0], sdaS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (stb.shiftIn) rxShift <= rxNext;
  end

  assign evt.sclRise   = sclS & ~sclD;
  assign evt.sclFall   = ~sclS & sclD;
  assign evt.start     = sclS & sclD & sdaD & ~sdaS;
  assign evt.stop      = sclS & sclD & ~sdaD & sdaS;
  assign evt.sdaBit    = sdaS;
  assign evt.addrMatch = (rxNext[7:1] == DEV_ADDR);
  assign evt.rwBit     = rxNext[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxStrobe <= 1'b0;
      rxIsCmd  <= 1'b0;
      rxData   <= '0;
    end else begin
      rxStrobe <= stb.emitByte;
      if (stb.emitByte) begin
        rxIsCmd <= stb.emitIsCmd;
        rxData  <= rxNext;
      end
    end
  end

  // ---------------- response queue ----------------
  logic [7:0]       mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fifoCnt;
  logic             fifoEmpty, fifoFull, doPush, doPop;

  assign fifoEmpty = (fifoCnt == '0);
  assign fifoFull  = (fifoCnt == CNT_FULL);
  assign doPush    = rspPush & ~fifoFull;
  assign doPop     = stb.loadTx & ~fifoEmpty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= rspData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      fifoCnt <= fifoCnt + 1'b1;
      else if (doPop && !doPush) fifoCnt <= fifoCnt - 1'b1;
    end
  end

  // ---------------- transmit shifter ----------------
  logic [7:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= 8'hFF;
    else if (stb.loadTx) txShift <= fifoEmpty ? 8'hFF : mem[rdPtr];
    else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b1};
  end

  assign sdaDriveLow = stb.ackLow | (stb.txEn & ~txShift[7]);

  // ---------------- assertions ----------------
  assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoCnt <= CNT_FULL);

  assert_full_push_dropped_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && rspPush && !stb.loadTx) |=> fifoFull);

  assert_empty_reads_ff_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx && fifoEmpty && !rspPush) |=> (txShift == 8'hFF && fifoEmpty));

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  busEvt_t  evt,
  output ctrlStb_t stb
);

  tgtState_t  state;
  logic [2:0] bitIdx;
  logic [1:0] byteIdx;   // 0 = address, 1 = command, 2 = data (saturates)
  logic       rwRead;
  logic       ackHigh;   // the ninth SCL pulse of the current byte has risen
  logic       ackLow, txEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitIdx  <= '0;
      byteIdx <= '0;
      rwRead  <= 1'b0;
      ackHigh <= 1'b0;
      ackLow  <= 1'b0;
      txEn    <= 1'b0;
    end else if (evt.stop) begin
      state  <= ST_IDLE;
      ackLow <= 1'b0;
      txEn   <= 1'b0;
    end else if (evt.start) begin
      state   <= ST_RX;
      bitIdx  <= '0;
      byteIdx <= '0;
      rwRead  <= 1'b0;
      ackHigh <= 1'b0;
      ackLow  <= 1'b0;
      txEn    <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (evt.sclRise) begin
          if (bitIdx == 3'd7) begin
            bitIdx  <= '0;
            ackHigh <= 1'b0;
            if (byteIdx == 2'd0) begin
              if (evt.addrMatch) begin
                rwRead  <= evt.rwBit;
                byteIdx <= 2'd1;
                state   <= ST_RXACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              if (byteIdx == 2'd1) byteIdx <= 2'd2;
              state <= ST_RXACK;
            end
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_RXACK: begin
          if (evt.sclRise) ackHigh <= 1'b1;
          if (evt.sclFall) begin
            if (!ackHigh) begin
              ackLow <= 1'b1;
            end else begin
              ackLow <= 1'b0;
              bitIdx <= '0;
              if (rwRead) begin
                state <= ST_TX;
                txEn  <= 1'b1;
              end else begin
                state <= ST_RX;
              end
            end
          end
        end
        ST_TX: if (evt.sclRise) begin
          if (bitIdx == 3'd7) begin
            bitIdx  <= '0;
            ackHigh <= 1'b0;
            state   <= ST_TXACK;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
        ST_TXACK: begin
          if (evt.sclFall) begin
            if (!ackHigh) txEn <= 1'b0;
            else begin
              txEn  <= 1'b1;
              state <= ST_TX;
            end
          end
          if (evt.sclRise) begin
            if (evt.sdaBit) state <= ST_IDLE;   // controller NACK
            else ackHigh <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  logic inByteEnd;
  assign inByteEnd = (state == ST_RX) && evt.sclRise && (bitIdx == 3'd7)
                     && !evt.stop && !evt.start;

  always_comb begin
    stb           = '0;
    stb.shiftIn   = (state == ST_RX) && evt.sclRise;
    stb.emitByte  = inByteEnd && (byteIdx != 2'd0);
    stb.emitIsCmd = (byteIdx == 2'd1);
    stb.loadTx    = !evt.stop && !evt.start && evt.sclFall && ackHigh &&
                    (((state == ST_RXACK) && rwRead) || (state == ST_TXACK));
    stb.shiftTx   = (state == ST_TX) && evt.sclFall && !evt.stop && !evt.start;
    stb.ackLow    = ackLow;
    stb.txEn      = txEn;
  end

  // ---------------- assertions ----------------
  assert_ack_in_slot_R2: assert property (@(posedge clk) disable iff (!rstN)
    ackLow |-> (state == ST_RXACK));

  assert_strobe_write_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitByte |-> !rwRead);

  assert_tx_read_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    txEn |-> (rwRead && (state == ST_TX || state == ST_TXACK)));

  assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    evt.stop |=> (state == ST_IDLE && !ackLow && !txEn));

  assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rstN)
    (evt.start && !evt.stop) |=> (state == ST_RX && bitIdx == 3'd0 && byteIdx == 2'd0));

endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int FIFO_DEPTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  output logic       rxStrobe,
  output logic       rxIsCmd,
  output logic [7:0] rxData,
  input  logic       rspPush,
  input  logic [7:0] rspData
);

  busEvt_t  evt;
  ctrlStb_t stb;

  i2c_tgt_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .evt  (evt),
    .stb  (stb)
  );

  i2c_tgt_dp #(
    .DEV_ADDR    (DEV_ADDR),
    .FIFO_DEPTH  (FIFO_DEPTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .stb         (stb),
    .evt         (evt),
    .sdaDriveLow (sdaDriveLow),
    .rxStrobe    (rxStrobe),
    .rxIsCmd     (rxIsCmd),
    .rxData      (rxData),
    .rspPush     (rspPush),
    .rspData     (rspData)
  );

endmodule

// File: tb/i2c_cmd_target_tb.sv
module i2c_cmd_target_tb;

  localparam logic [6:0] ADDR = 7'h42;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic rspPush = 1'b0;
  logic [7:0] rspData = '0;
  logic sdaDriveLow, rxStrobe, rxIsCmd;
  logic [7:0] rxData;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaDriveLow;

  always #2.5 clk = ~clk;

  i2c_cmd_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .rxStrobe(rxStrobe), .rxIsCmd(rxIsCmd),
    .rxData(rxData), .rspPush(rspPush), .rspData(rspData)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [8:0] expQ[$];
  logic [7:0] rspModel[$];
  logic [8:0] expItem;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare every byte strobe against the scoreboard
  always @(negedge clk) begin
    if (rstN && rxStrobe && !done) begin
      if (expQ.size() == 0) check(1'b0, "R3/R10 unexpected byte strobe", rxData, 0);
      else begin
        expItem = expQ.pop_front();
        check({rxIsCmd, rxData} == expItem, "R4 byte strobe flag/data",
              {rxIsCmd, rxData}, expItem);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; waitq(Q);
    scl = 1'b1; waitq(Q);
    sdaM = 1'b0; waitq(Q);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitq(Q);
    scl = 1'b1; waitq(Q);
    sdaM = 1'b1; waitq(2 * Q);
  endtask

  task automatic writeBit(input bit b);
    sdaM = b; waitq(Q);
    scl = 1'b1; waitq(Q);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic readBit(output bit b);
    sdaM = 1'b1; waitq(Q);
    scl = 1'b1; waitq(Q / 2);
    b = sdaLine; waitq(Q / 2);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic wrByte(input logic [7:0] v, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    acked = ~b;
  endtask

  task automatic rdByte(output logic [7:0] v, input bit ctlAck);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(~ctlAck);
  endtask

  task automatic pushRsp(input logic [7:0] v);
    @(negedge clk);
    rspPush = 1'b1; rspData = v;
    @(negedge clk);
    rspPush = 1'b0;
    if (rspModel.size() < 16) rspModel.push_back(v);
  endtask

  function automatic logic [7:0] nextRsp();
    if (rspModel.size() == 0) return 8'hFF;
    return rspModel.pop_front();
  endfunction

  // write transfer: command then data, scoreboard fed before each byte
  task automatic writeXfer(input logic [7:0] cmd, input logic [7:0] d[$]);
    bit ack;
    i2cStart();
    wrByte({ADDR, 1'b0}, ack);
    check(ack, "R2 address ack (write)", ack, 1);
    expQ.push_back({1'b1, cmd});
    wrByte(cmd, ack);
    check(ack, "R5 command byte ack", ack, 1);
    foreach (d[i]) begin
      expQ.push_back({1'b0, d[i]});
      wrByte(d[i], ack);
      check(ack, "R5 data byte ack", ack, 1);
    end
    i2cStop();
  endtask

  // read transfer of n bytes, last one NACKed
  task automatic readXfer(input int n, input string tag);
    bit ack;
    logic [7:0] v, e;
    i2cStart();
    wrByte({ADDR, 1'b1}, ack);
    check(ack, "R2 address ack (read)", ack, 1);
    for (int i = 0; i < n; i++) begin
      e = nextRsp();
      rdByte(v, i != n - 1);
      check(v == e, tag, v, e);
    end
    check(!sdaDriveLow, "R8 SDA released after NACK", sdaDriveLow, 0);
    i2cStop();
  endtask

  initial begin
    bit ack;
    logic [7:0] d[$];
    logic [7:0] v;
    waitq(5);
    // R1: reset state
    check(!sdaDriveLow, "R1 SDA released in reset", sdaDriveLow, 0);
    check(!rxStrobe, "R1 no strobe in reset", rxStrobe, 0);
    rstN = 1'b1;
    waitq(10);
    check(!sdaDriveLow && !rxStrobe, "R1 idle after reset", {sdaDriveLow, rxStrobe}, 0);

    // R4/R5: write with command and several data bytes (counts 17, 26, 35)
    d = '{8'hC3, 8'h00, 8'hFF};
    writeXfer(8'h63, d);
    d = '{};
    writeXfer(8'h6C, d);

    // R3: foreign address ignored for the whole transfer
    i2cStart();
    wrByte({7'h13, 1'b0}, ack);
    check(!ack, "R3 no ack for foreign address", ack, 0);
    wrByte(8'h55, ack);
    check(!ack, "R3 no ack for bytes after foreign address", ack, 0);
    i2cStop();

    // R6: read in push order
    pushRsp(8'hA5); pushRsp(8'h3C); pushRsp(8'h01);
    readXfer(3, "R6 response order");

    // R7: empty queue gives 0xFF
    readXfer(2, "R7 empty queue returns FF");

    // R8: NACK after first byte leaves the second queued
    pushRsp(8'h5A); pushRsp(8'h96);
    readXfer(1, "R8 first byte before NACK");
    readXfer(2, "R8 byte after NACK kept, then FF");

    // R9: overflow dropped
    for (int i = 0; i < 18; i++) pushRsp(8'(8'h10 + i));
    readXfer(17, "R9 depth 16 then FF");

    // R10: STOP in the middle of a byte, then a clean transfer
    i2cStart();
    wrByte({ADDR, 1'b0}, ack);
    check(ack, "R10 address ack before abort", ack, 1);
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1); writeBit(1'b1);
    i2cStop();
    check(!sdaDriveLow, "R10 idle after abort", sdaDriveLow, 0);
    d = '{8'h2E};
    writeXfer(8'h70, d);

    // R10: repeated START switches to a read at the address byte
    pushRsp(8'hE7);
    i2cStart();
    wrByte({ADDR, 1'b0}, ack);
    expQ.push_back({1'b1, 8'h11});
    wrByte(8'h11, ack);
    check(ack, "R10 command ack before repeated start", ack, 1);
    i2cStart();
    wrByte({ADDR, 1'b1}, ack);
    check(ack, "R10 address ack after repeated start", ack, 1);
    rdByte(v, 1'b0);
    check(v == 8'hE7, "R10 read after repeated start", v, 8'hE7);
    void'(nextRsp());
    i2cStop();

    waitq(20);
    check(expQ.size() == 0, "R4 all expected strobes seen", expQ.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule